// File: doc/BRIEF.md
# Working Register File with Indirect Pointers

This block is the general-purpose register store of a small 8-bit processor core. It holds thirty-two byte-wide registers. Two combinational read ports and one edge-triggered write port serve register-to-register and single-register operations. The read port A and the write port also accept a short immediate-form index that can only name the upper half of the file.

The top six registers double as three 16-bit little-endian address pointers. Any one of them can be read as a whole word. A pointer write replaces both of its bytes on the same clock edge, which is what post-increment and pre-decrement addressing need.

A data-space port maps the registers into the lowest 32 data addresses, so loads and stores aimed there land in the file instead of memory. A hit output tells the surrounding memory logic whether the address fell in that window.

Top module: `wreg_file`

## Requirements
- R1: While rst_ni is low, every register is cleared to 0x00 asynchronously.
- R2: When wr_en_i=1, the register chosen by the write index takes wr_data_i on the rising clock edge. All 32 registers are reachable when wr_imm_i=0. A read of that register in the same cycle still returns the value it held before the edge.
- R3: rd_a_data_o and rd_b_data_o combinationally return the registers named by rd_a_idx_i and rd_b_idx_i, independently of each other. With rd_a_imm_i=0, rd_a_idx_i is used as a full 5-bit index.
- R4: With wr_imm_i=1 (or rd_a_imm_i=1), bits [3:0] of the index, k, select register 16+k, and bit 4 of the index is ignored.
- R5: ptr_data_o returns a pointer chosen by ptr_sel_i. The encodings are 0 for {r27,r26}, 1 for {r29,r28} and 2 for {r31,r30}, with the odd register as the high byte. Encoding 3 reads 0x0000.
- R6: When ptr_we_i=1, the pointer chosen by ptr_wsel_i (same encoding as R5) takes ptr_wdata_i on one edge, low byte into the even register and high byte into the odd register. Encoding 3 writes nothing.
- R7: When ds_addr_i < 0x0020, ds_hit_o=1 and ds_rdata_o returns register ds_addr_i. When ds_we_i=1, that register takes ds_wdata_i on the edge.
- R8: When ds_addr_i >= 0x0020, ds_hit_o=0, ds_rdata_o=0x00, and a store with ds_we_i=1 changes no register.
- R9: When several write sources target the same register in one cycle, the order of precedence is pointer write, then data-space store, then write port. Writes that target different registers all take effect on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_a_idx_i | input | 5 | Read port A index |
| rd_a_imm_i | input | 1 | Read port A uses the immediate-form index |
| rd_a_data_o | output | 8 | Read port A data |
| rd_b_idx_i | input | 5 | Read port B index |
| rd_b_data_o | output | 8 | Read port B data |
| wr_en_i | input | 1 | Write port enable |
| wr_idx_i | input | 5 | Write port index |
| wr_imm_i | input | 1 | Write port uses the immediate-form index |
| wr_data_i | input | 8 | Write port data |
| ptr_sel_i | input | 2 | Pointer read select |
| ptr_data_o | output | 16 | Pointer read word |
| ptr_we_i | input | 1 | Pointer write enable |
| ptr_wsel_i | input | 2 | Pointer write select |
| ptr_wdata_i | input | 16 | Pointer write word |
| ds_addr_i | input | 16 | Data-space address |
| ds_we_i | input | 1 | Data-space store enable |
| ds_wdata_i | input | 8 | Data-space store data |
| ds_rdata_o | output | 8 | Data-space load data |
| ds_hit_o | output | 1 | Address falls in the register window |

## Verification
Random traffic drives all three write sources at once with colliding and disjoint targets. Comparing every read path against a reference model each cycle separates correct precedence from a wrong source winning. Data-space addresses are split between the register window and the full 16-bit range, with the edges 0x001F, 0x0020 and 0xFFFF tried directly, so that a faulty range compare shows up as a stray write or a wrong hit. Immediate indices are given with bit 4 set, so that decoding that leaks into the lower half can be told apart from correct decoding. Pointer select 3 is used on both the read and the write side.

// File: rtl/wreg_pkg.sv
package wreg_pkg;
  localparam int unsigned NUM_REGS = 32;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned IDX_W    = $clog2(NUM_REGS);
  localparam int unsigned IMM_W    = IDX_W - 1;
  localparam int unsigned NUM_PTRS = 3;
  localparam int unsigned PTR_W    = 2 * DATA_W;

  typedef enum logic [1:0] {
    PTR_X    = 2'd0,
    PTR_Y    = 2'd1,
    PTR_Z    = 2'd2,
    PTR_NONE = 2'd3
  } ptr_sel_e;
endpackage

// File: rtl/wreg_idx_dec.sv
module wreg_idx_dec #(
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic             imm_i,
  output logic [IDX_W-1:0] idx_o
);
  // immediate form: low bits index into the upper half
  always_comb begin
    idx_o = idx_i;
    if (imm_i) idx_o = {1'b1, idx_i[IDX_W-2:0]};
  end
endmodule

// File: rtl/wreg_ds_dec.sv
module wreg_ds_dec #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned IDX_W    = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int unsigned HI_W = ADDR_W - IDX_W;

  assign hit_o = (addr_i[ADDR_W-1:IDX_W] == HI_W'(0));
  assign idx_o = addr_i[IDX_W-1:0];
endmodule

// File: rtl/wreg_ptr_map.sv
module wreg_ptr_map #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned NUM_PTRS = 3,
  parameter int unsigned IDX_W    = 5
) (
  input  logic [1:0]       sel_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] lo_idx_o,
  output logic [IDX_W-1:0] hi_idx_o
);
  localparam int unsigned BASE = NUM_REGS - 2 * NUM_PTRS;

  always_comb begin
    valid_o  = (32'(sel_i) < NUM_PTRS);
    lo_idx_o = IDX_W'(BASE + 2 * 32'(sel_i));
    hi_idx_o = IDX_W'(BASE + 2 * 32'(sel_i) + 1);
    if (!valid_o) begin
      lo_idx_o = '0;
      hi_idx_o = '0;
    end
  end
endmodule

// File: rtl/wreg_file.sv
module wreg_file
  import wreg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  input  logic              rd_a_imm_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_imm_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        ptr_sel_i,
  output logic [PTR_W-1:0]  ptr_data_o,
  input  logic              ptr_we_i,
  input  logic [1:0]        ptr_wsel_i,
  input  logic [PTR_W-1:0]  ptr_wdata_i,
  input  logic [ADDR_W-1:0] ds_addr_i,
  input  logic              ds_we_i,
  input  logic [DATA_W-1:0] ds_wdata_i,
  output logic [DATA_W-1:0] ds_rdata_o,
  output logic              ds_hit_o
);
  localparam int unsigned UPPER = NUM_REGS / 2;
  localparam int unsigned PBASE = NUM_REGS - 2 * NUM_PTRS;
  localparam int unsigned Z_LO  = PBASE + 2 * 2;

  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

  logic [IDX_W-1:0] rd_a_idx, wr_idx, ds_idx;
  logic [IDX_W-1:0] prd_lo, prd_hi, pwr_lo, pwr_hi;
  logic             prd_ok, pwr_ok;

  wreg_idx_dec #(.IDX_W(IDX_W)) u_rd_a_dec (
    .idx_i(rd_a_idx_i), .imm_i(rd_a_imm_i), .idx_o(rd_a_idx));
  wreg_idx_dec #(.IDX_W(IDX_W)) u_wr_dec (
    .idx_i(wr_idx_i), .imm_i(wr_imm_i), .idx_o(wr_idx));

  wreg_ds_dec #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_ds_dec (
    .addr_i(ds_addr_i), .hit_o(ds_hit_o), .idx_o(ds_idx));

  wreg_ptr_map #(.NUM_REGS(NUM_REGS), .NUM_PTRS(NUM_PTRS), .IDX_W(IDX_W)) u_prd_map (
    .sel_i(ptr_sel_i), .valid_o(prd_ok), .lo_idx_o(prd_lo), .hi_idx_o(prd_hi));
  wreg_ptr_map #(.NUM_REGS(NUM_REGS), .NUM_PTRS(NUM_PTRS), .IDX_W(IDX_W)) u_pwr_map (
    .sel_i(ptr_wsel_i), .valid_o(pwr_ok), .lo_idx_o(pwr_lo), .hi_idx_o(pwr_hi));

  // reads
  assign rd_a_data_o = regs_q[rd_a_idx];
  assign rd_b_data_o = regs_q[rd_b_idx_i];
  assign ptr_data_o  = prd_ok ? {regs_q[prd_hi], regs_q[prd_lo]} : '0;
  assign ds_rdata_o  = ds_hit_o ? regs_q[ds_idx] : '0;

  // per-register write arbitration: pointer > data space > write port
  for (genvar n = 0; n < NUM_REGS; n++) begin : g_reg
    logic              sel_plo, sel_phi, sel_ds, sel_wr;
    logic [DATA_W-1:0] nxt;

    assign sel_plo = ptr_we_i && pwr_ok && (pwr_lo == IDX_W'(n));
    assign sel_phi = ptr_we_i && pwr_ok && (pwr_hi == IDX_W'(n));
    assign sel_ds  = ds_we_i && ds_hit_o && (ds_idx == IDX_W'(n));
    assign sel_wr  = wr_en_i && (wr_idx == IDX_W'(n));

    always_comb begin
      nxt = regs_q[n];
      if (sel_plo)      nxt = ptr_wdata_i[DATA_W-1:0];
      else if (sel_phi) nxt = ptr_wdata_i[PTR_W-1:DATA_W];
      else if (sel_ds)  nxt = ds_wdata_i;
      else if (sel_wr)  nxt = wr_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[n] <= '0;
      else         regs_q[n] <= nxt;
    end
  end

  // R2: lone write port update lands at the decoded index
  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !ptr_we_i && !ds_we_i |=> regs_q[$past(wr_idx)] == $past(wr_data_i));

  // R4: immediate form reaches upper half via index arithmetic
  a_r4_imm_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_imm_i && !ptr_we_i && !ds_we_i |=>
      regs_q[UPPER + 32'($past(wr_idx_i[IMM_W-1:0]))] == $past(wr_data_i));

  // R6: pointer Z word write updates both bytes together
  a_r6_ptr_z_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_we_i && ptr_wsel_i == PTR_Z |=>
      {regs_q[Z_LO+1], regs_q[Z_LO]} == $past(ptr_wdata_i));

  // R8: a store outside the window leaves the file alone
  a_r8_miss_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_we_i && !ds_hit_o && !wr_en_i && !ptr_we_i |=> regs_q == $past(regs_q));

  // R5: unused select reads zero
  a_r5_none_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_sel_i == PTR_NONE |-> ptr_data_o == '0);
endmodule

// File: tb/wreg_file_tb.sv
module wreg_file_tb;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic [4:0]  rd_a_idx_i = 0, rd_b_idx_i = 0, wr_idx_i = 0;
  logic        rd_a_imm_i = 0, wr_en_i = 0, wr_imm_i = 0;
  logic [7:0]  rd_a_data_o, rd_b_data_o, wr_data_i = 0, ds_wdata_i = 0, ds_rdata_o;
  logic [1:0]  ptr_sel_i = 0, ptr_wsel_i = 0;
  logic [15:0] ptr_data_o, ptr_wdata_i = 0, ds_addr_i = 16'h100;
  logic        ptr_we_i = 0, ds_we_i = 0, ds_hit_o;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] m [32];
  bit done = 0;

  always #5 clk_i = ~clk_i;

  wreg_file u_dut (.*);

  function automatic logic [4:0] eff_idx(logic [4:0] idx, logic imm);
    return imm ? (5'd16 + {1'b0, idx[3:0]}) : idx;
  endfunction

  function automatic logic [15:0] exp_ptr(logic [1:0] s);
    if (s == 2'd3) return 16'h0;
    return {m[27 + 2*s], m[26 + 2*s]};
  endfunction

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string pick(string tag, string dflt);
    return (tag != "") ? tag : dflt;
  endfunction

  // outputs are checked away from edge against model state before the edge
  task automatic cycle(string tag);
    logic hit;
    #2;
    chk(pick(tag, rd_a_imm_i ? "R4" : "R3"), "rd_a", 16'(rd_a_data_o),
        16'(m[eff_idx(rd_a_idx_i, rd_a_imm_i)]));
    chk(pick(tag, "R3"), "rd_b", 16'(rd_b_data_o), 16'(m[rd_b_idx_i]));
    chk(pick(tag, "R5"), "ptr", ptr_data_o, exp_ptr(ptr_sel_i));
    hit = (ds_addr_i < 16'h20);
    chk(pick(tag, hit ? "R7" : "R8"), "ds_hit", 16'(ds_hit_o), 16'(hit));
    chk(pick(tag, hit ? "R7" : "R8"), "ds_rdata", 16'(ds_rdata_o),
        hit ? 16'(m[ds_addr_i[4:0]]) : 16'h0);
    @(posedge clk_i);
    // model update, lowest precedence first (R9)
    if (wr_en_i) m[eff_idx(wr_idx_i, wr_imm_i)] = wr_data_i;
    if (ds_we_i && hit) m[ds_addr_i[4:0]] = ds_wdata_i;
    if (ptr_we_i && ptr_wsel_i != 2'd3) begin
      m[26 + 2*ptr_wsel_i] = ptr_wdata_i[7:0];
      m[27 + 2*ptr_wsel_i] = ptr_wdata_i[15:8];
    end
    @(negedge clk_i);
  endtask

  task automatic idle();
    wr_en_i = 0; ds_we_i = 0; ptr_we_i = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) m[i] = 8'h0;
    #23 @(negedge clk_i);
    // R1: reset state on every register
    for (int i = 0; i < 32; i++) begin
      rd_a_idx_i = 5'(i); rd_b_idx_i = 5'(31 - i);
      cycle("R1");
    end
    rst_ni = 1;
    @(negedge clk_i);

    // R2: write 5, same-cycle read shows old value, next shows new
    rd_a_idx_i = 5'd5; wr_en_i = 1; wr_idx_i = 5'd5; wr_data_i = 8'hA5;
    cycle("R2");
    idle();
    chk("R2", "after write", 16'(rd_a_data_o), 16'h00A5);
    cycle("R2");

    // R4: immediate with bit4 set still hits 16+3
    wr_en_i = 1; wr_imm_i = 1; wr_idx_i = 5'b1_0011; wr_data_i = 8'h3C;
    cycle("R4");
    idle(); wr_imm_i = 0;
    rd_a_imm_i = 1; rd_a_idx_i = 5'b0_0011; rd_b_idx_i = 5'd3;
    cycle("R4");
    chk("R4", "lower reg untouched", 16'(rd_b_data_o), 16'h0);
    chk("R4", "reg19", 16'(rd_a_data_o), 16'h003C);
    rd_a_imm_i = 0;

    // R6: pointer word write Y, then read back; select 3 writes nothing
    ptr_we_i = 1; ptr_wsel_i = 2'd1; ptr_wdata_i = 16'h1234;
    cycle("R6");
    ptr_wsel_i = 2'd3; ptr_wdata_i = 16'hFFFF;
    cycle("R6");
    idle();
    ptr_sel_i = 2'd1; rd_a_idx_i = 5'd29; rd_b_idx_i = 5'd28;
    cycle("R6");
    chk("R6", "Y word", ptr_data_o, 16'h1234);
    for (int s = 0; s < 4; s++) begin
      ptr_sel_i = 2'(s);
      cycle("R6");
    end

    // R9: three writers on register 26
    wr_en_i = 1; wr_idx_i = 5'd26; wr_data_i = 8'h11;
    ds_we_i = 1; ds_addr_i = 16'd26; ds_wdata_i = 8'h22;
    ptr_we_i = 1; ptr_wsel_i = 2'd0; ptr_wdata_i = 16'hBE33;
    cycle("R9");
    // data space over write port on 10, while pointer Z goes elsewhere
    wr_idx_i = 5'd10; ds_addr_i = 16'd10; ptr_wsel_i = 2'd2; ptr_wdata_i = 16'h5566;
    cycle("R9");
    idle();
    rd_a_idx_i = 5'd26; rd_b_idx_i = 5'd10; ptr_sel_i = 2'd2;
    cycle("R9");
    chk("R9", "r26", 16'(rd_a_data_o), 16'h0033);
    chk("R9", "r10", 16'(rd_b_data_o), 16'h0022);

    // R7 / R8 boundary addresses
    ds_we_i = 1; ds_addr_i = 16'h001F; ds_wdata_i = 8'h7E;
    cycle("R7");
    ds_addr_i = 16'h0020; ds_wdata_i = 8'h99;
    cycle("R8");
    ds_addr_i = 16'hFFFF;
    cycle("R8");
    idle();
    for (int i = 0; i < 32; i++) begin
      rd_a_idx_i = 5'(i); rd_b_idx_i = 5'(i);
      ds_addr_i = (i[0]) ? 16'h0020 : 16'(i);
      cycle("R8");
    end

    // constrained random mix
    for (int it = 0; it < 3000; it++) begin
      rd_a_idx_i  = 5'($urandom);
      rd_a_imm_i  = 1'($urandom);
      rd_b_idx_i  = 5'($urandom);
      wr_en_i     = ($urandom % 3) != 0;
      wr_idx_i    = 5'($urandom);
      wr_imm_i    = 1'($urandom);
      wr_data_i   = 8'($urandom);
      ptr_sel_i   = 2'($urandom);
      ptr_we_i    = ($urandom % 4) == 0;
      ptr_wsel_i  = 2'($urandom);
      ptr_wdata_i = 16'($urandom);
      ds_we_i     = 1'($urandom);
      ds_addr_i   = ($urandom % 2) ? 16'($urandom % 32) : 16'($urandom);
      ds_wdata_i  = 8'($urandom);
      cycle("");
    end
    idle();
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (200000) @(posedge clk_i);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule